// File: doc/BRIEF.md
# Address Field Move Engine

This engine carries out one address-move operation between two character fields held in a character-addressed memory. A host pulses a start strobe with a source start address, a destination start address and a two-digit length (tens digit and units digit). The engine walks both fields from the most significant (lowest-addressed) character towards the least significant one. It issues its reads and writes through a single request channel, and read data returns on a response channel.

Characters are 7 bits wide, with bit 1 in position [0] and bit 7 in position [6]. Every character except the final one is merged: the destination keeps its bits 6 and 7 and takes bits 1 to 5 from the source. The final character is copied whole, including bit 7, which marks whether a stored address belongs to the shared common area. When the final write is accepted, the engine reports a condition code: 1 when that bit 7 was set, 3 when it was clear. A plain numeric move would carry only the low four bits, and it is the fifth bit and the area bit that make this move suited to addresses.

The request channel uses valid/ready. A request (valid, we, address, write data) is offered and held unchanged until ready is seen high at a clock edge. Ready may drop at any time. A read's data must come back with rsp_valid some cycles after the read is accepted. The engine has at most one request outstanding and always accepts a response. Both fields are addressed modulo 2^ADDR_W.

Top module: `amov_engine`

## Requirements
- R1: The transfer length is 10*len_tens + len_units characters, with both digits in 0..9, and the digit pair 0/0 means 100. Exactly that many writes are issued per operation.
- R2: The writes go to dst_addr, dst_addr+1, … in ascending order. Each character is read from the source before it is written, so an overlapping forward copy propagates, just as a one-at-a-time left-to-right copy would.
- R3: For every character except the last, the written value is {destination bits 7..6, source bits 5..1}, using the values read for that character.
- R4: The last character is written equal to the source character, all 7 bits.
- R5: In the cycle after the final write is accepted, done is high for one cycle and cond_code is 1 if bit 7 ([6]) of the final source character is 1, else 3. cond_code holds until the next completion and never takes 2 or 4.
- R6: busy rises in the cycle after an accepted start and falls together with done. A start while busy has no effect on the ongoing operation, and it does not begin a new one.
- R7: While req_valid is high and req_ready is low, req_valid, req_we, req_addr and req_wdata stay stable.
- R8: Reset is active low and asynchronous. After reset, busy, done, req_valid and cond_code are all 0.
- R9: For a non-last character, the order is: source read, then destination read, then write. For the last character, the order is: source read, then write. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| src_addr | input | ADDR_W | First (most significant) source character address |
| dst_addr | input | ADDR_W | First (most significant) destination character address |
| len_tens | input | 4 | Tens digit of the length |
| len_units | input | 4 | Units digit of the length |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cond_code | output | 3 | Condition code, 1 or 3 after a completion |
| req_valid | output | 1 | Memory request offered |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_we | output | 1 | 1 for write, 0 for read |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | 7 | Write data |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 7 | Read data |

## Verification
The assertions assume that length digits offered with an accepted start are decimal (0..9). They also assume the memory returns exactly one response per accepted read, and only while the engine is waiting for it. The bench's memory model answers each read one cycle after acceptance and never otherwise. It applies random back-pressure on ready. Random lengths are drawn as two digits in 0..9, and addresses are chosen so that both fields stay inside the modelled window.

// File: rtl/amov_pkg.sv
package amov_pkg;
  localparam int CHAR_W  = 7;
  localparam int LOW_N   = 5;
  localparam int HIGH_N  = CHAR_W - LOW_N;
  localparam int MAX_LEN = 100;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [HIGH_N-1:0] zone_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_REQ,
    ST_SRC_WAIT,
    ST_DST_REQ,
    ST_DST_WAIT,
    ST_WRITE
  } state_t;

  function automatic char_t merge_char(input char_t src, input zone_t dst_zone);
    return {dst_zone, src[LOW_N-1:0]};
  endfunction
endpackage

// File: rtl/amov_len.sv
module amov_len
  import amov_pkg::*;
(
  input  logic [3:0] tens,
  input  logic [3:0] units,
  output cnt_t       total
);
  localparam cnt_t TEN  = cnt_t'(10);
  localparam cnt_t FULL = cnt_t'(MAX_LEN);

  cnt_t raw;
  always_comb begin
    raw   = cnt_t'(tens) * TEN + cnt_t'(units);
    total = (raw == '0) ? FULL : raw;
  end
endmodule

// File: rtl/amov_seq.sv
module amov_seq
  import amov_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_ok,
  input  cnt_t   total,
  input  logic   req_ready,
  input  logic   rsp_valid,
  output state_t state,
  output cnt_t   idx,
  output logic   last,
  output logic   busy,
  output logic   done,
  output logic   cap_src,
  output logic   cap_dst
);
  cnt_t   total_q;
  state_t nxt;

  assign last    = (idx == cnt_t'(total_q - cnt_t'(1)));
  assign busy    = (state != ST_IDLE);
  assign cap_src = (state == ST_SRC_WAIT) && rsp_valid;
  assign cap_dst = (state == ST_DST_WAIT) && rsp_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (start_ok)  nxt = ST_SRC_REQ;
      ST_SRC_REQ:  if (req_ready) nxt = ST_SRC_WAIT;
      ST_SRC_WAIT: if (rsp_valid) nxt = last ? ST_WRITE : ST_DST_REQ;
      ST_DST_REQ:  if (req_ready) nxt = ST_DST_WAIT;
      ST_DST_WAIT: if (rsp_valid) nxt = ST_WRITE;
      ST_WRITE:    if (req_ready) nxt = last ? ST_IDLE : ST_SRC_REQ;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      total_q <= '0;
      done    <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_WRITE) && req_ready && last;
      if (state == ST_IDLE && start_ok) begin
        idx     <= '0;
        total_q <= total;
      end else if (state == ST_WRITE && req_ready && !last) begin
        idx <= idx + cnt_t'(1);
      end
    end
  end

  // R9: a request state is left only through its handshake
  a_r9_req_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SRC_REQ || state == ST_DST_REQ || state == ST_WRITE) && !req_ready)
      |=> (state == $past(state)));

  // R1: index stays inside the programmed length while busy
  a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < total_q) && (total_q <= cnt_t'(MAX_LEN)) && (total_q != '0));

  // R6: busy only ends with a completion pulse
  a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: destination is read before a non-last write
  a_r9_dst_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_WRITE) && !last |-> $past(state) == ST_DST_WAIT);
endmodule

// File: rtl/amov_dp.sv
module amov_dp
  import amov_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  state_t            state,
  input  cnt_t              idx,
  input  logic              last,
  input  logic              busy,
  input  logic              cap_src,
  input  logic              cap_dst,
  input  logic              req_ready,
  input  char_t             rsp_data,
  output logic              req_valid,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output char_t             req_wdata,
  output logic [2:0]        cond_code
);
  localparam logic [2:0] CC_COMMON = 3'd1;
  localparam logic [2:0] CC_PART   = 3'd3;

  logic [ADDR_W-1:0] src_q, dst_q;
  char_t             src_char;
  zone_t             dst_zone;

  always_comb begin
    req_valid = (state == ST_SRC_REQ) || (state == ST_DST_REQ) || (state == ST_WRITE);
    req_we    = (state == ST_WRITE);
    req_addr  = ((state == ST_SRC_REQ) ? src_q : dst_q) + ADDR_W'(idx);
    req_wdata = last ? src_char : merge_char(src_char, dst_zone);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      dst_q     <= '0;
      src_char  <= '0;
      dst_zone  <= '0;
      cond_code <= '0;
    end else begin
      if (start_ok) begin
        src_q <= src_addr;
        dst_q <= dst_addr;
      end
      if (cap_src) src_char <= rsp_data;
      if (cap_dst) dst_zone <= rsp_data[CHAR_W-1:LOW_N];
      if (state == ST_WRITE && req_ready && last)
        cond_code <= src_char[CHAR_W-1] ? CC_COMMON : CC_PART;
    end
  end

  // R7: an offered request does not change until taken
  a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_we) && $stable(req_addr) && $stable(req_wdata));

  // R6: a start while busy leaves the field bases untouched
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(src_q) && $stable(dst_q));
endmodule

// File: rtl/amov_engine.sv
module amov_engine
  import amov_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [3:0]        len_tens,
  input  logic [3:0]        len_units,
  output logic              busy,
  output logic              done,
  output logic [2:0]        cond_code,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [6:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [6:0]        rsp_data
);
  state_t st;
  cnt_t   idx, total;
  logic   last, cap_src, cap_dst, start_ok;

  assign start_ok = start && !busy;

  amov_len u_len (
    .tens  (len_tens),
    .units (len_units),
    .total (total)
  );

  amov_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .total     (total),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .state     (st),
    .idx       (idx),
    .last      (last),
    .busy      (busy),
    .done      (done),
    .cap_src   (cap_src),
    .cap_dst   (cap_dst)
  );

  amov_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .start     (start),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .state     (st),
    .idx       (idx),
    .last      (last),
    .busy      (busy),
    .cap_src   (cap_src),
    .cap_dst   (cap_dst),
    .req_ready (req_ready),
    .rsp_data  (rsp_data),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cond_code (cond_code)
  );

  // R5: completion reports only codes 1 or 3
  a_r5_code_values: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cond_code == 3'd1 || cond_code == 3'd3));

  // R1: accepted starts carry decimal digits
  a_r1_digits: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (len_tens <= 4'd9) && (len_units <= 4'd9));

  // R6: busy follows an accepted start
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
endmodule

// File: tb/tb_amov_engine.sv
module tb_amov_engine;
  localparam int AW = 17;
  localparam int MW = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [3:0]    len_tens = '0, len_units = '0;
  logic          busy, done, req_valid, req_we;
  logic [2:0]    cond_code;
  logic          req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic [6:0]    req_wdata;
  logic          rsp_valid = 1'b0;
  logic [6:0]    rsp_data = '0;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [6:0] mem [MW];
  logic [6:0] ref_m [MW];
  int  wr_cnt = 0, exp_dst = 0, order_bad = 0;
  bit  bp_en = 1'b0;

  always #2 clk = ~clk;

  amov_engine #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .len_tens(len_tens), .len_units(len_units), .busy(busy), .done(done),
    .cond_code(cond_code), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always @(negedge clk) req_ready <= bp_en ? (($urandom % 4) != 0) : 1'b1;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (rst_n && req_valid && req_ready) begin
      if (req_we) begin
        mem[req_addr[11:0]] <= req_wdata;
        if (int'(req_addr[11:0]) != ((exp_dst + wr_cnt) % MW)) order_bad <= order_bad + 1;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[req_addr[11:0]];
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 190000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(input int t, input int u);
    return (t * 10 + u == 0) ? 100 : t * 10 + u;
  endfunction

  task automatic run(input int s, input int d, input int t, input int u, input bit poke);
    int L, exp_cc, bad, wc;
    logic [6:0] sv, dv;
    L = len_of(t, u);
    for (int i = 0; i < MW; i++) ref_m[i] = mem[i];
    exp_cc = 3;
    for (int i = 0; i < L; i++) begin
      sv = ref_m[(s + i) % MW];
      dv = ref_m[(d + i) % MW];
      if (i == L - 1) begin
        ref_m[(d + i) % MW] = sv;
        exp_cc = sv[6] ? 1 : 3;
      end else begin
        ref_m[(d + i) % MW] = {dv[6:5], sv[4:0]};
      end
    end
    @(negedge clk);
    wr_cnt = 0; order_bad = 0; exp_dst = d;
    start = 1'b1; src_addr = AW'(s); dst_addr = AW'(d);
    len_tens = 4'(t); len_units = 4'(u);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; src_addr = AW'((s + 7) % 3000); dst_addr = AW'((d + 300) % 3000);
      len_tens = 4'd0; len_units = 4'd3;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(cond_code == 3'(exp_cc), "R5 cond code", int'(cond_code), exp_cc);
    chk(busy == 1'b0, "R6 busy falls with done", int'(busy), 0);
    chk(wr_cnt == L, "R1 write count", wr_cnt, L);
    chk(order_bad == 0, "R2 ascending write order", order_bad, 0);
    chk(mem[(d + L - 1) % MW] == ref_m[(d + L - 1) % MW], "R4 last char intact",
        int'(mem[(d + L - 1) % MW]), int'(ref_m[(d + L - 1) % MW]));
    bad = 0;
    for (int i = 0; i < MW; i++) if (mem[i] !== ref_m[i]) bad++;
    chk(bad == 0, "R3 merged field contents", bad, 0);
    if (poke) begin
      wc = wr_cnt;
      repeat (12) @(negedge clk);
      chk(wr_cnt == wc && !busy, "R6 start while busy ignored", wr_cnt, wc);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MW; i++) mem[i] = 7'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && cond_code == 3'd0, "R8 reset state",
        int'({busy, done, req_valid, cond_code}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    mem[1000 + 99] = 7'b1000101;
    run(1000, 2000, 0, 0, 1'b0);          // R1 0/0 means 100, R5 common code
    mem[300] = 7'b0010110;
    run(300, 400, 0, 1, 1'b0);            // single character, R5 partition code
    run(500, 1500, 9, 9, 1'b0);           // 99 characters
    run(600, 601, 1, 0, 1'b0);            // R2 overlapping forward copy
    run(700, 800, 0, 4, 1'b1);            // R6 start during busy
    bp_en = 1'b1;
    run(900, 950, 0, 2, 1'b0);            // R7/R9 under back-pressure
    for (int k = 0; k < 30; k++)
      run(int'($urandom % 3800), int'($urandom % 3800),
          int'($urandom % 10), int'($urandom % 10), 1'($urandom % 5 == 0));
    summary();
  end
endmodule